// File: doc/BRIEF.md
# Miss-Source History Request Predictor

This block sits beside one cache partition. It remembers where that partition's recent misses were served from: another partition's cache (cache-to-cache) or main memory. From that memory it advises each new miss on two things. The first is whether to broadcast a peer-to-peer request to every partition or to send a mediated request to the coherence gateway alone. The second is whether a speculative memory prefetch should travel with the request.

Instruction-fetch misses and data misses are tracked apart, in two 64-bit shift histories. Every served miss shifts one bit into the history of its class. A 1 means it was served cache-to-cache. A 0 means it was served from memory. A query names the class of the new miss. One cycle later the block returns the request mode and the prefetch bit, both derived from that class's history as it stood at the query edge. When cache-to-cache service is common, the block favours peer requests. When memory service dominates, it favours mediated requests with prefetch.

Top module: `miss_src_predictor`

## Requirements
- R1: After reset both histories are all zeros, so the first query of either class answers mediated (`req_peer`=0) with prefetch on (`pf_en`=1). While reset is held, `rsp_valid`, `req_peer` and `pf_en` are 0.
- R2: A cycle with `srv_valid`=1 shifts one bit into the history selected by `srv_is_code` (1 = code, 0 = data). The bit is 1 when `srv_from_c2c`=1 and 0 for memory.
- R3: A served event of one class leaves the other class's history, and therefore its answers, unchanged.
- R4: `req_peer` is 1 (peer-to-peer) exactly when the count of ones in the queried class's history is at least P2P_THRESH (default 32). Otherwise it is 0 (mediated).
- R5: `pf_en` is 1 exactly when the count of zeros (memory-sourced) in the queried history is at least PF_THRESH (default 48).
- R6: `rsp_valid` is 1 in the cycle after a cycle with `qry_valid`=1. In that same cycle `req_peer` and `pf_en` carry the answer to that query. After a cycle without a query, they hold their previous values.
- R7: When a query and a served event of the same class share a cycle, the answer uses the history from before that event.
- R8: Only the 64 most recent events of a class count. Older events drop out of the history.
- R9: `rsp_valid` is 0 in any cycle that does not follow a query.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| srv_valid | input | 1 | A miss has been served this cycle |
| srv_is_code | input | 1 | Class of the served miss: 1 code, 0 data |
| srv_from_c2c | input | 1 | Source of the served miss: 1 cache-to-cache, 0 memory |
| qry_valid | input | 1 | A new miss asks for advice this cycle |
| qry_is_code | input | 1 | Class of the new miss: 1 code, 0 data |
| rsp_valid | output | 1 | Answer to the previous cycle's query is present |
| req_peer | output | 1 | 1 peer-to-peer broadcast, 0 mediated request |
| pf_en | output | 1 | Send a speculative memory prefetch |

## Verification
The hardest state to reach is a history that sits exactly on a threshold edge while older events are ageing out. This happens when a class has seen more than 64 events, and a query must tell whether the 65th-oldest bit has really left the count. Directed sequences fill one class to exactly 31/32 ones and 16/17 ones. They then push 64 opposite events through it and query the other class between steps. Biased random phases then sweep the c2c rate up and down, so the counts cross both thresholds many times, including with a query and a served event of the same class in one cycle.

// File: rtl/msp_pkg.sv
package msp_pkg;
  typedef enum logic {
    MODE_MEDIATED = 1'b0,
    MODE_PEER     = 1'b1
  } req_mode_e;

  typedef enum logic {
    CLS_DATA = 1'b0,
    CLS_CODE = 1'b1
  } miss_cls_e;

  localparam int NUM_CLS = 2;
endpackage

// File: rtl/msp_hist.sv
module msp_hist #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] hist
);
  logic [W-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        hist_q <= '0;
    else if (shift_en) hist_q <= {hist_q[W-2:0], bit_in};
  end

  assign hist = hist_q;
endmodule

// File: rtl/msp_decide.sv
module msp_decide #(
  parameter int W      = 64,
  parameter int P2P_TH = 32,
  parameter int PF_TH  = 48
) (
  input  logic [W-1:0] hist,
  output logic         peer,
  output logic         pf
);
  localparam int CW = $clog2(W + 1);

  function automatic logic [CW-1:0] ones_of(input logic [W-1:0] v);
    logic [CW-1:0] acc;
    acc = '0;
    for (int i = 0; i < W; i++) acc = acc + CW'(v[i]);
    return acc;
  endfunction

  logic [CW-1:0] c2c_cnt;
  logic [CW-1:0] mem_cnt;

  always_comb begin
    c2c_cnt = ones_of(hist);
    mem_cnt = CW'(W) - c2c_cnt;
    peer    = (c2c_cnt >= CW'(P2P_TH));
    pf      = (mem_cnt >= CW'(PF_TH));
  end
endmodule

// File: rtl/miss_src_predictor.sv
module miss_src_predictor
  import msp_pkg::*;
#(
  parameter int HIST_W     = 64,
  parameter int P2P_THRESH = 32,
  parameter int PF_THRESH  = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic srv_valid,
  input  logic srv_is_code,
  input  logic srv_from_c2c,
  input  logic qry_valid,
  input  logic qry_is_code,
  output logic rsp_valid,
  output logic req_peer,
  output logic pf_en
);
  logic [HIST_W-1:0] hist_w [NUM_CLS];
  logic [NUM_CLS-1:0] peer_w;
  logic [NUM_CLS-1:0] pf_w;

  // One history and one decision path per miss class.
  for (genvar gc = 0; gc < NUM_CLS; gc++) begin : g_cls
    logic sel;
    assign sel = srv_valid && (srv_is_code == gc[0]);

    msp_hist #(.W(HIST_W)) u_hist (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (sel),
      .bit_in   (srv_from_c2c),
      .hist     (hist_w[gc])
    );

    msp_decide #(.W(HIST_W), .P2P_TH(P2P_THRESH), .PF_TH(PF_THRESH)) u_dec (
      .hist (hist_w[gc]),
      .peer (peer_w[gc]),
      .pf   (pf_w[gc])
    );
  end

  // Named views for the checker.
  logic [HIST_W-1:0] code_hist;
  logic [HIST_W-1:0] data_hist;
  assign code_hist = hist_w[CLS_CODE];
  assign data_hist = hist_w[CLS_DATA];

  req_mode_e mode_d;
  logic      pf_d;
  assign mode_d = qry_is_code ? req_mode_e'(peer_w[CLS_CODE]) : req_mode_e'(peer_w[CLS_DATA]);
  assign pf_d   = qry_is_code ? pf_w[CLS_CODE] : pf_w[CLS_DATA];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      req_peer  <= 1'b0;
      pf_en     <= 1'b0;
    end else begin
      rsp_valid <= qry_valid;
      if (qry_valid) begin
        req_peer <= (mode_d == MODE_PEER);
        pf_en    <= pf_d;
      end
    end
  end
endmodule

// File: rtl/msp_checker.sv
module msp_checker #(
  parameter int W      = 64,
  parameter int P2P_TH = 32,
  parameter int PF_TH  = 48
) (
  input logic         clk,
  input logic         rst_n,
  input logic         srv_valid,
  input logic         srv_is_code,
  input logic         srv_from_c2c,
  input logic         qry_valid,
  input logic         qry_is_code,
  input logic         rsp_valid,
  input logic         req_peer,
  input logic         pf_en,
  input logic [W-1:0] code_hist,
  input logic [W-1:0] data_hist
);
  p_rsp_follows_query_r6: assert property (@(posedge clk) disable iff (!rst_n)
    qry_valid |=> rsp_valid);

  p_no_spurious_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !qry_valid |=> !rsp_valid);

  p_hold_answer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !qry_valid |=> ($stable(req_peer) && $stable(pf_en)));

  p_code_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (srv_valid && srv_is_code) |=>
      (code_hist[0] == $past(srv_from_c2c)) && (code_hist[W-1:1] == $past(code_hist[W-2:0])));

  p_data_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (srv_valid && !srv_is_code) |=>
      (data_hist[0] == $past(srv_from_c2c)) && (data_hist[W-1:1] == $past(data_hist[W-2:0])));

  p_data_isolated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(srv_valid && !srv_is_code) |=> $stable(data_hist));

  p_code_isolated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(srv_valid && srv_is_code) |=> $stable(code_hist));

  p_mode_pick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    qry_valid |=> req_peer ==
      ($countones($past(qry_is_code) ? $past(code_hist) : $past(data_hist)) >= P2P_TH));

  p_prefetch_pick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    qry_valid |=> pf_en ==
      ((W - $countones($past(qry_is_code) ? $past(code_hist) : $past(data_hist))) >= PF_TH));
endmodule

bind miss_src_predictor msp_checker #(
  .W(HIST_W), .P2P_TH(P2P_THRESH), .PF_TH(PF_THRESH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .srv_valid(srv_valid), .srv_is_code(srv_is_code),
  .srv_from_c2c(srv_from_c2c), .qry_valid(qry_valid), .qry_is_code(qry_is_code),
  .rsp_valid(rsp_valid), .req_peer(req_peer), .pf_en(pf_en),
  .code_hist(code_hist), .data_hist(data_hist)
);

// File: tb/miss_src_predictor_tb.sv
`timescale 1ns/1ps
module miss_src_predictor_tb;
  localparam int HW  = 64;
  localparam int PTH = 32;
  localparam int FTH = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic srv_valid = 1'b0, srv_is_code = 1'b0, srv_from_c2c = 1'b0;
  logic qry_valid = 1'b0, qry_is_code = 1'b0;
  logic rsp_valid, req_peer, pf_en;

  always #2 clk = ~clk;

  miss_src_predictor u_dut (
    .clk(clk), .rst_n(rst_n), .srv_valid(srv_valid), .srv_is_code(srv_is_code),
    .srv_from_c2c(srv_from_c2c), .qry_valid(qry_valid), .qry_is_code(qry_is_code),
    .rsp_valid(rsp_valid), .req_peer(req_peer), .pf_en(pf_en)
  );

  int total = 0;
  int bad   = 0;
  logic [HW-1:0] m_code = '0;
  logic [HW-1:0] m_data = '0;
  logic exp_peer = 1'b0, exp_pf = 1'b0;

  function automatic int c2c_of(input logic [HW-1:0] h);
    int n = 0;
    logic [HW-1:0] t = h;
    while (t != '0) begin
      t = t & (t - 1'b1);
      n++;
    end
    return n;
  endfunction

  function automatic logic want_peer(input logic [HW-1:0] h);
    return c2c_of(h) >= PTH;
  endfunction

  function automatic logic want_pf(input logic [HW-1:0] h);
    return (HW - c2c_of(h)) >= FTH;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle of stimulus; the answer is checked right after the edge.
  task automatic step(input logic sv, input logic sc, input logic sf,
                      input logic qv, input logic qc, input string req);
    @(negedge clk);
    srv_valid = sv; srv_is_code = sc; srv_from_c2c = sf;
    qry_valid = qv; qry_is_code = qc;
    if (qv) begin
      // R7: answer from the history before this cycle's event
      exp_peer = want_peer(qc ? m_code : m_data);
      exp_pf   = want_pf(qc ? m_code : m_data);
    end
    if (sv) begin
      if (sc) m_code = {m_code[HW-2:0], sf};
      else    m_data = {m_data[HW-2:0], sf};
    end
    @(posedge clk);
    #1;
    chk({req, " R6/R9 rsp_valid"}, rsp_valid, qv);
    chk({req, " R4 req_peer"}, req_peer, exp_peer);
    chk({req, " R5 pf_en"}, pf_en, exp_pf);
  endtask

  task automatic fill(input logic sc, input logic sf, input int n);
    for (int i = 0; i < n; i++) step(1'b1, sc, sf, 1'b0, 1'b0, "fill");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset rsp_valid", rsp_valid, 1'b0);
    chk("R1 reset req_peer", req_peer, 1'b0);
    chk("R1 reset pf_en", pf_en, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R1 first data query");
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R1 first code query");
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R9 idle");

    // Peer threshold boundary on data: 31 then 32 c2c events
    fill(1'b0, 1'b1, 31);
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R4 data at 31");
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R7 same-cycle event");
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R4 data at 32");
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R3 code untouched");

    // Prefetch boundary on code: 16 then 17 c2c events
    fill(1'b1, 1'b1, 16);
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R5 code at 16");
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R2 code shift");
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R5 code at 17");
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R3 data untouched");

    // Ageing: 64 memory events flush data c2c bits
    for (int i = 0; i < HW; i++) begin
      step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R8 ageing data");
      if (i % 8 == 0) step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R3 code during ageing");
    end
    fill(1'b1, 1'b1, 80);
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R8 code saturated");

    // Biased random phases
    void'($urandom(32'd1234));
    for (int ph = 0; ph < 8; ph++) begin
      int bias = (ph * 37) % 8;
      for (int k = 0; k < 400; k++) begin
        logic sv = ($urandom % 4) != 0;
        logic sc = $urandom % 2;
        logic sf = ($urandom % 8) < bias;
        logic qv = ($urandom % 3) != 0;
        logic qc = $urandom % 2;
        step(sv, sc, sf, qv, qc, "R2/R4/R5 random");
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule